// File: doc/BRIEF.md
# Ingress Packet Priority Classifier

This block gives every received packet a 2-bit priority level and turns that level into an egress queue index that fits the queue mode in force. The frame parser supplies the ingress port number, a flag that says whether the frame carries a VLAN tag, and the tag's 3-bit priority code point. Each port has its own configuration: a fixed priority level, an enable for port-based classification and an enable for tag-based classification. All ports share an eight-entry table that converts a tag priority to a level.

A tagged frame that arrives on a port with tag-based classification enabled takes its level from the table. Otherwise the port's fixed level is used when port-based classification is enabled, and the level is 0 when neither applies. The egress queue mode then sets the final index. With one queue the index is always 0. With four queues the level is the index. With two queues a 2-bit threshold control splits the levels into high and low. The header strobe is registered, so the result appears one cycle after it.

Top module: `pcls_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid, out_queue and out_level are all 0 after that edge.
- R2: out_valid is 1 in the cycle after a cycle with hdr_valid high, and 0 otherwise. When hdr_valid is low, out_queue and out_level keep their previous values.
- R3: If tag_prio_en[p] is 1 and hdr_tagged is 1, the level is entry n of pcp_map, where n is hdr_pcp and entry n occupies pcp_map[2n+1:2n].
- R4: If tag-based classification does not apply and port_prio_en[p] is 1, the level is port p's fixed level, held in port_prio[2p+1:2p].
- R5: If neither tag-based nor port-based classification applies, the level is 0.
- R6: With queue_mode 2'b00 (single queue) or 2'b11 (reserved, treated as single queue), out_queue is 0.
- R7: With queue_mode 2'b10 (four queues), out_queue equals the level, so 3 is the highest queue.
- R8: With queue_mode 2'b01 (two queues), out_queue is 1 (high) when two_q_ctl is not 2'b11 and the level is at least two_q_ctl+1. In every other case it is 0 (low). A two_q_ctl of 2'b11 therefore sends every level to low.
- R9: A hdr_port value of NUM_PORTS or above selects no configuration, so the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Strobe: header fields are valid this cycle |
| hdr_port | input | PORT_W | Ingress port index |
| hdr_tagged | input | 1 | Frame carries a VLAN tag |
| hdr_pcp | input | 3 | Tag priority code point |
| port_prio | input | 2*NUM_PORTS | Fixed level per port, port p at [2p+1:2p] |
| port_prio_en | input | NUM_PORTS | Per-port enable for port-based classification |
| tag_prio_en | input | NUM_PORTS | Per-port enable for tag-based classification |
| pcp_map | input | 16 | Tag priority to level table, entry n at [2n+1:2n] |
| two_q_ctl | input | 2 | Threshold used in two-queue mode |
| queue_mode | input | 2 | 00 single, 01 two, 10 four, 11 single |
| out_valid | output | 1 | Result valid |
| out_queue | output | 2 | Egress queue index |
| out_level | output | 2 | Resolved priority level |

## Verification
The bench uses the defaults, NUM_PORTS = 5 with a derived PORT_W of 3. This leaves port indices 5 to 7 free to exercise the out-of-range case (R9) next to the five real ports. Random headers, per-port settings, tables and modes reach every combination of the two enables, the tagged flag and the four queue modes. Directed cases cover each two-queue threshold, including the all-low setting, and the hold behaviour between strobes.

// File: rtl/pcls_pkg.sv
// Package: shared types and constants of the priority classifier.
// Assumes a 3-bit tag priority and 2-bit levels throughout.
package pcls_pkg;
    localparam int PCP_W       = 3;
    localparam int LVL_W       = 2;
    localparam int MAP_ENTRIES = 1 << PCP_W;
    localparam int MAP_W       = MAP_ENTRIES * LVL_W;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [1:0] {
        QM_SINGLE = 2'b00,
        QM_DUAL   = 2'b01,
        QM_QUAD   = 2'b10,
        QM_RSVD   = 2'b11
    } qmode_e;
endpackage

// File: rtl/pcls_port_cfg_sel.sv
// Module: picks the configuration of the ingress port out of the per-port
// vectors. Assumes the vectors are packed with port p at the low-order end.
// An index with no matching port yields all zeros (both enables off).
module pcls_port_cfg_sel
    import pcls_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 3
) (
    input  logic [PORT_W-1:0]          port_idx,
    input  logic [NUM_PORTS*LVL_W-1:0] port_prio,
    input  logic [NUM_PORTS-1:0]       port_prio_en,
    input  logic [NUM_PORTS-1:0]       tag_prio_en,
    output level_t                     sel_prio,
    output logic                       sel_port_en,
    output logic                       sel_tag_en
);
    logic [NUM_PORTS-1:0] hit;
    level_t               prio_arr [NUM_PORTS];

    // one decoder compare and one unpacked level per port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign hit[p]      = (port_idx == PORT_W'(p));
        assign prio_arr[p] = port_prio[p*LVL_W +: LVL_W];
    end

    // AND-OR multiplexer over the one-hot hit vector
    always_comb begin
        sel_prio    = '0;
        sel_port_en = 1'b0;
        sel_tag_en  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            sel_prio    = sel_prio | (prio_arr[p] & {LVL_W{hit[p]}});
            sel_port_en = sel_port_en | (port_prio_en[p] & hit[p]);
            sel_tag_en  = sel_tag_en  | (tag_prio_en[p]  & hit[p]);
        end
    end
endmodule

// File: rtl/pcls_pcp_lut.sv
// Module: converts a tag priority code point to a level through the shared
// table. Assumes entry n of the table sits at bits [2n+1:2n].
module pcls_pcp_lut
    import pcls_pkg::*;
(
    input  logic [MAP_W-1:0] pcp_map,
    input  logic [PCP_W-1:0] pcp,
    output level_t           level
);
    level_t entry [MAP_ENTRIES];

    // unpack the flat table into entries
    for (genvar n = 0; n < MAP_ENTRIES; n++) begin : g_entry
        assign entry[n] = pcp_map[n*LVL_W +: LVL_W];
    end

    // index the table
    always_comb level = entry[pcp];
endmodule

// File: rtl/pcls_level_resolve.sv
// Module: decides which classification source sets the level.
// Tag result first, then the port's fixed level, otherwise 0.
module pcls_level_resolve
    import pcls_pkg::*;
(
    input  logic   tagged_i,
    input  logic   tag_en,
    input  logic   port_en,
    input  level_t tag_level,
    input  level_t port_level,
    output level_t level
);
    // fixed precedence chain
    always_comb begin
        if (tag_en && tagged_i)
            level = tag_level;
        else if (port_en)
            level = port_level;
        else
            level = '0;
    end
endmodule

// File: rtl/pcls_queue_fold.sv
// Module: turns a level into a queue index for the egress queue mode.
// In two-queue mode the threshold is ctl+1 and a ctl of 3 sends everything low.
module pcls_queue_fold
    import pcls_pkg::*;
(
    input  qmode_e     mode,
    input  logic [1:0] ctl,
    input  level_t     level,
    output logic [1:0] queue
);
    logic high;

    // threshold compare in 3 bits so ctl+1 cannot wrap
    always_comb high = (ctl != 2'b11) && ({1'b0, level} >= ({1'b0, ctl} + 3'd1));

    // select the index by mode
    always_comb begin
        unique case (mode)
            QM_DUAL: queue = {1'b0, high};
            QM_QUAD: queue = level;
            default: queue = 2'b00;
        endcase
    end
endmodule

// File: rtl/pcls_top.sv
// Module: ingress priority classifier top. Takes the parsed header fields and
// the static configuration, and registers the level and queue index one cycle
// after hdr_valid. Assumes the configuration inputs are stable around a strobe.
module pcls_top
    import pcls_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hdr_valid,
    input  logic [PORT_W-1:0]          hdr_port,
    input  logic                       hdr_tagged,
    input  logic [2:0]                 hdr_pcp,
    input  logic [NUM_PORTS*2-1:0]     port_prio,
    input  logic [NUM_PORTS-1:0]       port_prio_en,
    input  logic [NUM_PORTS-1:0]       tag_prio_en,
    input  logic [15:0]                pcp_map,
    input  logic [1:0]                 two_q_ctl,
    input  logic [1:0]                 queue_mode,
    output logic                       out_valid,
    output logic [1:0]                 out_queue,
    output logic [1:0]                 out_level
);
    level_t     sel_prio, tag_level, level_c;
    logic       sel_port_en, sel_tag_en;
    logic [1:0] queue_c;

    pcls_port_cfg_sel #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_cfg_sel (
        .port_idx     (hdr_port),
        .port_prio    (port_prio),
        .port_prio_en (port_prio_en),
        .tag_prio_en  (tag_prio_en),
        .sel_prio     (sel_prio),
        .sel_port_en  (sel_port_en),
        .sel_tag_en   (sel_tag_en)
    );

    pcls_pcp_lut i_lut (
        .pcp_map (pcp_map),
        .pcp     (hdr_pcp),
        .level   (tag_level)
    );

    pcls_level_resolve i_resolve (
        .tagged_i   (hdr_tagged),
        .tag_en     (sel_tag_en),
        .port_en    (sel_port_en),
        .tag_level  (tag_level),
        .port_level (sel_prio),
        .level      (level_c)
    );

    pcls_queue_fold i_fold (
        .mode  (qmode_e'(queue_mode)),
        .ctl   (two_q_ctl),
        .level (level_c),
        .queue (queue_c)
    );

    // output register: valid follows the strobe, data loads only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_queue <= '0;
            out_level <= '0;
        end else begin
            out_valid <= hdr_valid;
            if (hdr_valid) begin
                out_queue <= queue_c;
                out_level <= level_c;
            end
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !out_valid);
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !hdr_valid) |=> ($stable(out_queue) && $stable(out_level)));
    assert_single_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (queue_mode == 2'b00 || queue_mode == 2'b11)) |=> (out_queue == 2'b00));
    assert_quad_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && queue_mode == 2'b10) |=> (out_queue == out_level));
    assert_dual_all_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && queue_mode == 2'b01 && two_q_ctl == 2'b11) |=> (out_queue == 2'b00));
endmodule

// File: tb/test_pcls_top.sv
module test_pcls_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hdr_valid = 1'b0;
    logic [PW-1:0] hdr_port = '0;
    logic hdr_tagged = 1'b0;
    logic [2:0] hdr_pcp = '0;
    logic [NP*2-1:0] port_prio = '0;
    logic [NP-1:0] port_prio_en = '0;
    logic [NP-1:0] tag_prio_en = '0;
    logic [15:0] pcp_map = 16'hFA50;
    logic [1:0] two_q_ctl = '0;
    logic [1:0] queue_mode = '0;
    logic out_valid;
    logic [1:0] out_queue, out_level;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    pcls_top i_pcls_top (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_port(hdr_port),
        .hdr_tagged(hdr_tagged), .hdr_pcp(hdr_pcp), .port_prio(port_prio),
        .port_prio_en(port_prio_en), .tag_prio_en(tag_prio_en), .pcp_map(pcp_map),
        .two_q_ctl(two_q_ctl), .queue_mode(queue_mode), .out_valid(out_valid),
        .out_queue(out_queue), .out_level(out_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // level expected from R3, R4, R5 and R9
    function automatic logic [1:0] exp_level();
        int p = int'(hdr_port);
        if (p >= NP) return 2'd0;
        if (tag_prio_en[p] && hdr_tagged) return pcp_map[2*hdr_pcp +: 2];
        if (port_prio_en[p]) return port_prio[2*p +: 2];
        return 2'd0;
    endfunction

    // queue expected from R6, R7 and R8
    function automatic logic [1:0] exp_queue(logic [1:0] lvl);
        case (queue_mode)
            2'b10: return lvl;
            2'b01: return (two_q_ctl != 2'b11 && int'(lvl) >= int'(two_q_ctl) + 1) ? 2'd1 : 2'd0;
            default: return 2'd0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobe: drive at negedge, sample at the next negedge
    task automatic send(string req);
        logic [1:0] el, eq;
        el = exp_level();
        eq = exp_queue(el);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R2 valid", int'(out_valid), 1);
        check({req, " level"}, int'(out_level), int'(el));
        check({req, " queue"}, int'(out_queue), int'(eq));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] hq, hl;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 queue", int'(out_queue), 0);
        check("R1 level", int'(out_level), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", int'(out_valid), 0);

        // R3: tag path on port 1, four queues
        queue_mode = 2'b10; tag_prio_en = 5'b00010; port_prio_en = 5'b00010;
        port_prio = 10'b00_00_00_01_00; hdr_port = 3'd1; hdr_tagged = 1'b1;
        for (int n = 0; n < 8; n++) begin hdr_pcp = 3'(n); send("R3"); end
        // R4: untagged falls back to the fixed level
        hdr_tagged = 1'b0; send("R4");
        // R5: nothing enabled
        port_prio_en = '0; tag_prio_en = '0; hdr_tagged = 1'b1; send("R5");
        // R9: out-of-range ports with everything enabled
        port_prio_en = '1; tag_prio_en = '1; port_prio = '1;
        for (int p = 5; p < 8; p++) begin hdr_port = 3'(p); send("R9"); end
        // R6: single and reserved modes
        hdr_port = 3'd4; queue_mode = 2'b00; send("R6");
        queue_mode = 2'b11; send("R6");
        // R8: every threshold at every level via port-based priority
        queue_mode = 2'b01; tag_prio_en = '0;
        for (int c = 0; c < 4; c++) begin
            two_q_ctl = 2'(c);
            for (int l = 0; l < 4; l++) begin port_prio[8 +: 2] = 2'(l); send("R8"); end
        end
        // R7: four queues, level 3 at the top
        queue_mode = 2'b10; send("R7");
        // R2: hold during idle
        hq = out_queue; hl = out_level;
        port_prio[8 +: 2] = 2'd0;
        repeat (3) @(negedge clk);
        check("R2 idle valid", int'(out_valid), 0);
        check("R2 hold queue", int'(out_queue), int'(hq));
        check("R2 hold level", int'(out_level), int'(hl));

        // random mix across R3 to R9
        for (int i = 0; i < 400; i++) begin
            hdr_port = PW'($urandom_range(0, 7));
            hdr_tagged = 1'($urandom);
            hdr_pcp = 3'($urandom);
            port_prio = NP*2'($urandom);
            port_prio_en = NP'($urandom);
            tag_prio_en = NP'($urandom);
            pcp_map = 16'($urandom);
            two_q_ctl = 2'($urandom);
            queue_mode = 2'($urandom);
            send("R3-mix");
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                check("R2 gap", int'(out_valid), 0);
            end
        end

        // R1: reset in mid-stream clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 again valid", int'(out_valid), 0);
        check("R1 again queue", int'(out_queue), 0);
        check("R1 again level", int'(out_level), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule